// File: doc/BRIEF.md
# Signed multiply-accumulate datapath

This unit is the multiply-accumulate slice of a DSP core that keeps its data and its program in separate memories. It holds two 16-bit signed operand registers. X takes its value from the data-memory bus or from the low half of the 32-bit result bus. Y takes its value from the data-memory bus or from the program-memory bus. The control unit drives a separate strobe for every register load and every select, so the unit decodes no instruction of its own.

Each operation multiplies the present contents of X and Y into a 32-bit signed product. In multiply-only operation the product replaces the result. Otherwise it is sign-extended to 40 bits and added to the result. The 40-bit result is held as a 32-bit low word and an 8-bit guard byte. Operand loads and operations can be issued in the same cycle, so a repeated multiply-accumulate runs at one term per clock.

The result leaves the unit on the shared 32-bit result bus in two lanes: a 24-bit upper lane and an 8-bit lower lane. The low word takes one unload cycle. The guard byte takes a second cycle, in which it rides the lower lane and the upper lane carries its sign.

Top module: `mac_unit`

## Requirements
- R1: After reset both result registers are zero, so unloading the word or the guard byte puts 0 on the result bus.
- R2: With ld_x_i high, X takes dm_bus_i when x_sel_i=0 and r_bus_i[15:0] when x_sel_i=1. The new value is seen by operations from the next cycle on.
- R3: With ld_y_i high, Y takes dm_bus_i when y_sel_i=0 and pm_bus_i when y_sel_i=1. The new value is seen by operations from the next cycle on.
- R4: With mac_en_i and mul_only_i high, the low word becomes the signed product X*Y, and the guard byte becomes eight copies of product bit 31.
- R5: With mac_en_i high and both mul_only_i and acc_clr_i low, the 40-bit value {guard,word} becomes itself plus the sign-extended product, modulo 2^40. The operands used are the register contents before any load made in the same cycle, so back-to-back operations accumulate one term per cycle.
- R6: acc_clr_i with mac_en_i low clears both result registers. acc_clr_i with mac_en_i high loads the sign-extended product instead of adding it.
- R7: With unload_i=2'b01, r_bus_o[31:8] is word[31:8], r_bus_o[7:0] is word[7:0], and r_valid_o is 1.
- R8: With unload_i=2'b10, r_bus_o[7:0] is the guard byte, r_bus_o[31:8] repeats guard bit 7, and r_valid_o is 1.
- R9: With unload_i at 2'b00 or 2'b11, r_bus_o is 0 and r_valid_o is 0.
- R10: With mac_en_i and acc_clr_i both low, the result registers hold their value. An operand register whose load strobe is low holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dm_bus_i | input | 16 | Data-memory bus |
| pm_bus_i | input | 16 | Program-memory bus |
| r_bus_i | input | 32 | Result bus as seen by the unit; bits 15:0 can feed X |
| ld_x_i | input | 1 | Load strobe for X |
| x_sel_i | input | 1 | X source: 0 data memory, 1 result bus |
| ld_y_i | input | 1 | Load strobe for Y |
| y_sel_i | input | 1 | Y source: 0 data memory, 1 program memory |
| mac_en_i | input | 1 | Perform an operation this cycle |
| mul_only_i | input | 1 | The operation replaces the result with the product |
| acc_clr_i | input | 1 | Clear the result, or load the product in place of adding it |
| unload_i | input | 2 | 01 unloads the word, 10 unloads the guard byte, other values leave the bus idle |
| r_bus_o | output | 32 | Result bus drive |
| r_valid_o | output | 1 | High in each cycle in which r_bus_o carries a result |

## Verification
The bench builds the unit with its default widths: 16-bit operands, a 32-bit bus and an 8-bit guard. With these widths, runs of full-scale products carry the sum past bit 31 into the guard byte, and mixed-sign runs bring it back down through zero, so the guard-lane sign extension is exercised in both directions. A behavioural model with 40-bit wraparound is compared against the bus on every clock, through directed sequences and a long stretch of random strobes and data.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    UNL_NONE  = 2'b00,
    UNL_WORD  = 2'b01,
    UNL_GUARD = 2'b10,
    UNL_RSVD  = 2'b11
  } unload_e;
endpackage

// File: rtl/mac_operands.sv
module mac_operands #(
  parameter int OP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] dm_i,
  input  logic [OP_W-1:0] pm_i,
  input  logic [OP_W-1:0] rb_i,
  input  logic            ld_x_i,
  input  logic            x_sel_i,
  input  logic            ld_y_i,
  input  logic            y_sel_i,
  output logic [OP_W-1:0] x_o,
  output logic [OP_W-1:0] y_o
);
  localparam int NREG = 2;

  logic [NREG-1:0][OP_W-1:0] alt_src;
  logic [NREG-1:0]           ld, sel;
  logic [NREG-1:0][OP_W-1:0] q;

  // lane 0 = X (alt source result bus), lane 1 = Y (alt source program memory)
  assign alt_src = {pm_i, rb_i};
  assign ld      = {ld_y_i, ld_x_i};
  assign sel     = {y_sel_i, x_sel_i};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [OP_W-1:0] d;
    assign d = sel[g] ? alt_src[g] : dm_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q[g] <= '0;
      else if (ld[g]) q[g] <= d;
    end
  end

  assign x_o = q[0];
  assign y_o = q[1];
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int OP_W    = 16,
  parameter int BUS_W   = 32,
  parameter int GUARD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    x_i,
  input  logic [OP_W-1:0]    y_i,
  input  logic               mac_en_i,
  input  logic               mul_only_i,
  input  logic               acc_clr_i,
  output logic [BUS_W-1:0]   lo_o,
  output logic [GUARD_W-1:0] hi_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = BUS_W + GUARD_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, acc_q, acc_d;

  assign prod     = PROD_W'($signed(x_i)) * PROD_W'($signed(y_i));
  assign prod_ext = ACC_W'(prod);

  always_comb begin
    acc_d = acc_q;
    if (mac_en_i) begin
      if (mul_only_i || acc_clr_i) acc_d = prod_ext;  // bypass adder
      else                         acc_d = acc_q + prod_ext;
    end else if (acc_clr_i) begin
      acc_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign lo_o = acc_q[BUS_W-1:0];
  assign hi_o = acc_q[ACC_W-1:BUS_W];
endmodule

// File: rtl/mac_unload.sv
module mac_unload
  import mac_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int GUARD_W = 8
) (
  input  unload_e            mode_i,
  input  logic [BUS_W-1:0]   lo_i,
  input  logic [GUARD_W-1:0] hi_i,
  output logic [BUS_W-1:0]   bus_o,
  output logic               valid_o
);
  localparam int LO_W = GUARD_W;
  localparam int HI_W = BUS_W - LO_W;

  logic [HI_W-1:0] up_lane;
  logic [LO_W-1:0] dn_lane;

  always_comb begin
    up_lane = '0;
    dn_lane = '0;
    valid_o = 1'b0;
    unique case (mode_i)
      UNL_WORD: begin
        up_lane = lo_i[BUS_W-1:LO_W];
        dn_lane = lo_i[LO_W-1:0];
        valid_o = 1'b1;
      end
      UNL_GUARD: begin
        up_lane = {HI_W{hi_i[GUARD_W-1]}};
        dn_lane = hi_i;
        valid_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign bus_o = {up_lane, dn_lane};
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int BUS_W   = 32,
  parameter int GUARD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  dm_bus_i,
  input  logic [OP_W-1:0]  pm_bus_i,
  input  logic [BUS_W-1:0] r_bus_i,
  input  logic             ld_x_i,
  input  logic             x_sel_i,
  input  logic             ld_y_i,
  input  logic             y_sel_i,
  input  logic             mac_en_i,
  input  logic             mul_only_i,
  input  logic             acc_clr_i,
  input  logic [1:0]       unload_i,
  output logic [BUS_W-1:0] r_bus_o,
  output logic             r_valid_o
);
  logic [OP_W-1:0]    x_q, y_q;
  logic [BUS_W-1:0]   mr_lo;
  logic [GUARD_W-1:0] mr_hi;
  logic               unused_rbus;

  assign unused_rbus = ^r_bus_i[BUS_W-1:OP_W];

  mac_operands #(.OP_W(OP_W)) u_ops (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dm_i    (dm_bus_i),
    .pm_i    (pm_bus_i),
    .rb_i    (r_bus_i[OP_W-1:0]),
    .ld_x_i  (ld_x_i),
    .x_sel_i (x_sel_i),
    .ld_y_i  (ld_y_i),
    .y_sel_i (y_sel_i),
    .x_o     (x_q),
    .y_o     (y_q)
  );

  mac_accum #(.OP_W(OP_W), .BUS_W(BUS_W), .GUARD_W(GUARD_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .x_i        (x_q),
    .y_i        (y_q),
    .mac_en_i   (mac_en_i),
    .mul_only_i (mul_only_i),
    .acc_clr_i  (acc_clr_i),
    .lo_o       (mr_lo),
    .hi_o       (mr_hi)
  );

  mac_unload #(.BUS_W(BUS_W), .GUARD_W(GUARD_W)) u_unl (
    .mode_i  (unload_e'(unload_i)),
    .lo_i    (mr_lo),
    .hi_i    (mr_hi),
    .bus_o   (r_bus_o),
    .valid_o (r_valid_o)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OP_W    = 16,
  parameter int BUS_W   = 32,
  parameter int GUARD_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [OP_W-1:0]    dm_bus_i,
  input logic               ld_x_i,
  input logic               x_sel_i,
  input logic               mac_en_i,
  input logic               mul_only_i,
  input logic               acc_clr_i,
  input logic [1:0]         unload_i,
  input logic [BUS_W-1:0]   r_bus_o,
  input logic               r_valid_o,
  input logic [OP_W-1:0]    x_q,
  input logic [BUS_W-1:0]   mr_lo,
  input logic [GUARD_W-1:0] mr_hi
);
  p_xload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_x_i && !x_sel_i) |=> (x_q == $past(dm_bus_i)));

  p_mulonly_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_en_i && mul_only_i) |=> (mr_hi == {GUARD_W{mr_lo[BUS_W-1]}}));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_clr_i && !mac_en_i) |=> (mr_lo == '0 && mr_hi == '0));

  p_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unload_i == 2'b01) |-> (r_valid_o && r_bus_o == mr_lo));

  p_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unload_i == 2'b10) |-> (r_valid_o && r_bus_o[GUARD_W-1:0] == mr_hi
      && r_bus_o[BUS_W-1:GUARD_W] == {(BUS_W-GUARD_W){mr_hi[GUARD_W-1]}}));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unload_i == 2'b00 || unload_i == 2'b11) |-> (!r_valid_o && r_bus_o == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mac_en_i && !acc_clr_i) |=> ($stable(mr_lo) && $stable(mr_hi)));

  p_xhold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_x_i |=> $stable(x_q));
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .BUS_W(BUS_W), .GUARD_W(GUARD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dm_bus_i   (dm_bus_i),
  .ld_x_i     (ld_x_i),
  .x_sel_i    (x_sel_i),
  .mac_en_i   (mac_en_i),
  .mul_only_i (mul_only_i),
  .acc_clr_i  (acc_clr_i),
  .unload_i   (unload_i),
  .r_bus_o    (r_bus_o),
  .r_valid_o  (r_valid_o),
  .x_q        (x_q),
  .mr_lo      (mr_lo),
  .mr_hi      (mr_hi)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] dm = '0, pm = '0;
  logic [31:0] rb = '0;
  logic ld_x = 0, x_sel = 0, ld_y = 0, y_sel = 0;
  logic mac_en = 0, mul_only = 0, acc_clr = 0;
  logic [1:0] unload = 2'b00;
  logic [31:0] r_bus;
  logic r_valid;

  int checks = 0;
  int errors = 0;

  logic signed [15:0] mx = '0, my = '0;
  logic [39:0] macc = '0;

  always #10 clk = ~clk;

  mac_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .dm_bus_i(dm), .pm_bus_i(pm), .r_bus_i(rb),
    .ld_x_i(ld_x), .x_sel_i(x_sel), .ld_y_i(ld_y), .y_sel_i(y_sel),
    .mac_en_i(mac_en), .mul_only_i(mul_only), .acc_clr_i(acc_clr),
    .unload_i(unload), .r_bus_o(r_bus), .r_valid_o(r_valid)
  );

  task automatic idle_ctl();
    ld_x = 0; ld_y = 0; mac_en = 0; mul_only = 0; acc_clr = 0; unload = 2'b00;
  endtask

  // compare bus against model, then clock once and advance model
  task automatic step(input string tag);
    logic [31:0] exp_bus;
    logic        exp_v;
    string       ltag;
    logic signed [31:0] p;
    #1;
    case (unload)
      2'b01:   begin exp_bus = macc[31:0]; exp_v = 1; ltag = "R7"; end
      2'b10:   begin exp_bus = {{24{macc[39]}}, macc[39:32]}; exp_v = 1; ltag = "R8"; end
      default: begin exp_bus = '0; exp_v = 0; ltag = "R9"; end
    endcase
    checks++;
    if (r_bus !== exp_bus || r_valid !== exp_v) begin
      errors++;
      $display("FAIL %s/%s: bus=%h valid=%b expected bus=%h valid=%b",
               tag, ltag, r_bus, r_valid, exp_bus, exp_v);
    end
    @(posedge clk);
    p = mx * my;
    if (mac_en) begin
      if (mul_only || acc_clr) macc = {{8{p[31]}}, p};
      else                     macc = macc + {{8{p[31]}}, p};
    end else if (acc_clr) macc = '0;
    if (ld_x) mx = x_sel ? rb[15:0] : dm;
    if (ld_y) my = y_sel ? pm : dm;
    @(negedge clk);
  endtask

  task automatic dump(input string tag);
    idle_ctl(); unload = 2'b01; step(tag);
    unload = 2'b10; step(tag);
    unload = 2'b00;
  endtask

  task automatic ldops(input logic [15:0] a, input logic [15:0] b);
    ld_x = 1; x_sel = 0; dm = a; ld_y = 1; y_sel = 1; pm = b;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    dump("R1");
    unload = 2'b11; step("R9 reserved"); unload = 2'b00;

    // R2 R3 R4: X from dm, Y from dm, multiply only, negative product
    ld_x = 1; x_sel = 0; dm = 16'd3; step("R2");
    idle_ctl(); ld_y = 1; y_sel = 0; dm = 16'hFFFB; step("R3");
    idle_ctl(); mac_en = 1; mul_only = 1; step("R4");
    dump("R4");

    // R2 R3: X from result bus (junk upper half), Y from program memory
    idle_ctl(); ld_x = 1; x_sel = 1; rb = 32'hDEAD_0123; dm = 16'h7777;
    ld_y = 1; y_sel = 1; pm = 16'h0456; step("R2 R3");
    idle_ctl(); mac_en = 1; mul_only = 1; step("R4");
    dump("R2");

    // R6: clear, then load product with clear
    idle_ctl(); acc_clr = 1; step("R6"); dump("R6");
    idle_ctl(); mac_en = 1; acc_clr = 1; step("R6"); dump("R6");

    // R5: back-to-back accumulation past 32 bits, loads in the same cycle
    idle_ctl(); ldops(16'h7FFF, 16'h7FFF); step("R5");
    for (int i = 0; i < 10; i++) begin
      idle_ctl(); mac_en = 1; ldops(16'h7FFF, 16'h7FFF); step("R5");
    end
    dump("R5 guard positive");
    // drive negative across zero
    idle_ctl(); ldops(16'h8000, 16'h7FFF); step("R5");
    for (int i = 0; i < 24; i++) begin
      idle_ctl(); mac_en = 1; ldops(16'h8000, 16'h7FFF); step("R5");
    end
    dump("R5 guard negative");
    // alternating operands per cycle
    for (int i = 0; i < 6; i++) begin
      idle_ctl(); mac_en = 1; ldops(16'(i * 1234 - 3000), 16'(17 - i * 9)); step("R5");
    end
    dump("R5");

    // R10: hold with no strobes, junk on buses
    idle_ctl(); dm = 16'hAAAA; pm = 16'h5555; rb = 32'h1234_5678;
    step("R10"); step("R10"); dump("R10");
    idle_ctl(); mac_en = 1; mul_only = 1; step("R10 operands held"); dump("R10");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      dm = 16'($urandom); pm = 16'($urandom); rb = $urandom;
      ld_x = 1'($urandom); x_sel = 1'($urandom);
      ld_y = 1'($urandom); y_sel = 1'($urandom);
      mac_en = ($urandom % 4) != 0; mul_only = ($urandom % 8) == 0;
      acc_clr = ($urandom % 16) == 0; unload = 2'($urandom);
      step("R5 random");
    end
    dump("R5 random end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule